// File: doc/BRIEF.md
# GPIO External Interrupt Controller

This block watches a bank of external interrupt lines and turns activity on them into one interrupt request for the processor. Each line has its own trigger mode: rising edge, falling edge, both edges, high level or low level. An event seen on an enabled line is latched into a pending bit. The pending bits of enabled lines are ORed into a registered interrupt output.

Software reaches the block through a plain 32-bit register port addressed by byte offset. Writes are single-cycle strobes and reads are combinational from the addressed register. A handler reads the pending register and then writes that same value back to it, which clears exactly the events it has seen. Each raw input passes through a two-flop synchronizer. A third flop keeps the value from one clock earlier, and edge detection compares against it.

Top module: `eint_ctrl`

## Requirements
- R1: After reset, all mode fields, the enable register and the pending register read as zero, and `irq` is low.
- R2: The mode fields are 4 bits wide, eight lines to a register. Line n uses offset 0x200 + 4*(n/8) at bits 4*(n%8)+3 to 4*(n%8). The enable register is at 0x210, where bit n enables line n. The pending register is at 0x214, where bit n is line n. Mode and enable registers read back what was written. Reads of any other offset return zero.
- R3: Mode 0 (rising) sets the pending bit when the synchronized input goes from 0 to 1, and never on a 1-to-0 change or a steady input.
- R4: Mode 1 (falling) sets the pending bit on a 1-to-0 change only.
- R5: Mode 4 (both edges) sets the pending bit on either change.
- R6: Mode 2 (high level) sets the pending bit on every clock while the input is 1. A clear written while the level holds leaves the bit set.
- R7: Mode 3 (low level) sets the pending bit on every clock while the input is 0.
- R8: Mode values 5 to 15 never set the pending bit.
- R9: A pending bit is set only while its line is enabled. Events on a disabled line are not remembered, and they do not appear later when the line is enabled.
- R10: Writing 1 to a bit of the pending register clears that bit, and writing 0 leaves it unchanged. This holds whether or not the line is enabled.
- R11: When a set and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R12: `irq` is the registered OR over all lines of (pending AND enable). Disabling a line whose bit is pending drops `irq` one clock after the enable change takes effect.
- R13: Latency: an input change is captured by the first clock edge after it. The pending bit shows the change after the third edge, and `irq` follows after the fourth edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eint_in | input | NUM_LINES | Raw external interrupt lines, asynchronous |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| irq | output | 1 | Aggregated interrupt request, registered |

## Verification
The assertions take two things as given. Writes are single-cycle strobes with the address and data stable at the clock edge. Inputs that change between edges reach the detectors only through the synchronizer. Edge checks therefore compare the synchronized value with its delayed copy rather than with the raw pins. The stimulus changes pins and bus signals only on the falling clock edge. It holds each input steady for several cycles before enabling a line, so that no stale edge from the previous pattern lands in the enabled window. Level-mode patterns start from the inactive level for the same reason.

// File: rtl/eint_pkg.sv
package eint_pkg;

    // Trigger mode encodings held in each 4-bit field
    typedef enum logic [3:0] {
        TRIG_RISE = 4'd0,
        TRIG_FALL = 4'd1,
        TRIG_HIGH = 4'd2,
        TRIG_LOW  = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_e;

    localparam int DATA_W        = 32;
    localparam int FIELD_W       = 4;
    localparam int LINES_PER_CFG = DATA_W / FIELD_W;

    // Byte offsets of the register window
    localparam int CFG_BASE = 'h200;
    localparam int EN_OFS   = 'h210;
    localparam int STAT_OFS = 'h214;

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] lvl_d_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] lvl_q;
    logic [WIDTH-1:0] lvl_d_q;

    // Two metastability flops, then one more stage for edge comparison
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= '0;
            lvl_q   <= '0;
            lvl_d_q <= '0;
        end else begin
            meta_q  <= raw_i;
            lvl_q   <= meta_q;
            lvl_d_q <= lvl_q;
        end
    end

    assign lvl_o   = lvl_q;
    assign lvl_d_o = lvl_d_q;

endmodule

// File: rtl/eint_detect.sv
module eint_detect
    import eint_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic [NUM_LINES-1:0]         lvl_i,
    input  logic [NUM_LINES-1:0]         lvl_d_i,
    input  logic [NUM_LINES*FIELD_W-1:0] mode_i,
    output logic [NUM_LINES-1:0]         hit_o
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [FIELD_W-1:0] mode;
        assign mode = mode_i[i*FIELD_W +: FIELD_W];

        always_comb begin
            unique case (mode)
                TRIG_RISE: hit_o[i] =  lvl_i[i] & ~lvl_d_i[i];
                TRIG_FALL: hit_o[i] = ~lvl_i[i] &  lvl_d_i[i];
                TRIG_HIGH: hit_o[i] =  lvl_i[i];
                TRIG_LOW:  hit_o[i] = ~lvl_i[i];
                TRIG_BOTH: hit_o[i] =  lvl_i[i] ^  lvl_d_i[i];
                default:   hit_o[i] = 1'b0; // reserved codes
            endcase
        end
    end

endmodule

// File: rtl/eint_regs.sv
module eint_regs
    import eint_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wen,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [NUM_LINES-1:0]         hit_i,
    output logic [NUM_LINES*FIELD_W-1:0] mode_o,
    output logic                         irq_o
);

    localparam int NUM_CFG = (NUM_LINES + LINES_PER_CFG - 1) / LINES_PER_CFG;

    logic [DATA_W-1:0]    cfg_q [NUM_CFG];
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] stat_q;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] set_vec;
    logic                 irq_q;
    logic                 en_sel;
    logic                 stat_sel;

    assign en_sel   = (bus_addr == ADDR_W'(EN_OFS));
    assign stat_sel = (bus_addr == ADDR_W'(STAT_OFS));

    // Mode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_CFG; g++) cfg_q[g] <= '0;
        end else if (bus_wen) begin
            for (int g = 0; g < NUM_CFG; g++) begin
                if (bus_addr == ADDR_W'(CFG_BASE + 4 * g)) cfg_q[g] <= bus_wdata;
            end
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_mode
        assign mode_o[i*FIELD_W +: FIELD_W] =
            cfg_q[i / LINES_PER_CFG][(i % LINES_PER_CFG) * FIELD_W +: FIELD_W];
    end

    // Enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 en_q <= '0;
        else if (bus_wen && en_sel) en_q <= bus_wdata[NUM_LINES-1:0];
    end

    // Pending register: hardware set has priority over write-one clear
    assign clr_vec = (bus_wen && stat_sel) ? bus_wdata[NUM_LINES-1:0] : '0;
    assign set_vec = hit_i & en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat_q & en_q);
    end

    assign irq_o = irq_q;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_CFG; g++) begin
            if (bus_addr == ADDR_W'(CFG_BASE + 4 * g)) bus_rdata = cfg_q[g];
        end
        if (en_sel)   bus_rdata[NUM_LINES-1:0] = en_q;
        if (stat_sel) bus_rdata[NUM_LINES-1:0] = stat_q;
    end

    // R10: a written one clears the bit unless a new event lands in that cycle
    p_w1c_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && stat_sel) |=> ((stat_q & $past(bus_wdata[NUM_LINES-1:0] & ~(hit_i & en_q))) == '0));

    // R11: an event on an enabled line is never lost to a simultaneous clear
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit_i & en_q)) |=> ((stat_q & $past(hit_i & en_q)) == $past(hit_i & en_q)));

    // R9: newly set pending bits belong to lines that were enabled
    p_enabled_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

    // R12: the request only rises from an enabled pending bit
    p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(stat_q & en_q)));

endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] eint_in,
    input  logic                 bus_wen,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 irq
);

    logic [NUM_LINES-1:0]         lvl;
    logic [NUM_LINES-1:0]         lvl_d;
    logic [NUM_LINES-1:0]         hit;
    logic [NUM_LINES*FIELD_W-1:0] mode;

    eint_sync #(.WIDTH(NUM_LINES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (eint_in),
        .lvl_o   (lvl),
        .lvl_d_o (lvl_d)
    );

    eint_detect #(.NUM_LINES(NUM_LINES)) i_detect (
        .lvl_i   (lvl),
        .lvl_d_i (lvl_d),
        .mode_i  (mode),
        .hit_o   (hit)
    );

    eint_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hit_i     (hit),
        .mode_o    (mode),
        .irq_o     (irq)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        logic [FIELD_W-1:0] m;
        assign m = mode[i*FIELD_W +: FIELD_W];

        // R3 R4 R5: an edge-mode event needs a change on the synchronized line
        p_edge_needs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && (m == TRIG_RISE || m == TRIG_FALL || m == TRIG_BOTH))
                |-> (lvl[i] != lvl_d[i]));

        // R8: reserved codes stay quiet
        p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (m > FIELD_W'(TRIG_BOTH)) |-> !hit[i]);
    end

endmodule

// File: tb/test_eint_ctrl.sv
module test_eint_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_CFG0 = 12'h200;
    localparam logic [11:0] A_EN   = 12'h210;
    localparam logic [11:0] A_STAT = 12'h214;

    typedef struct packed {
        logic [4:0] line;
        logic [3:0] mode;
        logic       v0;
        logic       v1;
        logic       exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  4'd0,  1'b0, 1'b1, 1'b1},   // R3 rise
        '{5'd7,  4'd0,  1'b1, 1'b0, 1'b0},   // R3 fall ignored
        '{5'd8,  4'd1,  1'b1, 1'b0, 1'b1},   // R4
        '{5'd15, 4'd1,  1'b0, 1'b1, 1'b0},   // R4
        '{5'd16, 4'd4,  1'b0, 1'b1, 1'b1},   // R5
        '{5'd23, 4'd4,  1'b1, 1'b0, 1'b1},   // R5
        '{5'd24, 4'd2,  1'b0, 1'b1, 1'b1},   // R6
        '{5'd31, 4'd2,  1'b0, 1'b0, 1'b0},   // R6
        '{5'd9,  4'd3,  1'b1, 1'b0, 1'b1},   // R7
        '{5'd10, 4'd3,  1'b1, 1'b1, 1'b0},   // R7
        '{5'd11, 4'd5,  1'b0, 1'b1, 1'b0},   // R8
        '{5'd12, 4'd9,  1'b1, 1'b0, 1'b0},   // R8
        '{5'd13, 4'd15, 1'b0, 1'b1, 1'b0},   // R8
        '{5'd14, 4'd0,  1'b0, 1'b0, 1'b0}    // R3 steady
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] eint_in = '0;
    logic        bus_wen = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    eint_ctrl i_eint_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .eint_in   (eint_in),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen   = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        for (int g = 0; g < 4; g++) begin
            rd(A_CFG0 + 12'(4 * g), r); chk("R1 cfg", r, 32'h0);
        end
        rd(A_EN, r);   chk("R1 enable", r, 32'h0);
        rd(A_STAT, r); chk("R1 pending", r, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 register map
        wr(12'h204, 32'h1234_5678); rd(12'h204, r); chk("R2 cfg1", r, 32'h1234_5678);
        wr(A_EN, 32'h0);           rd(A_EN, r);    chk("R2 enable", r, 32'h0);
        wr(A_EN, 32'hA5A5_0000);   rd(A_EN, r);    chk("R2 enable", r, 32'hA5A5_0000);
        wr(A_EN, 32'h0);
        wr(12'h204, 32'h0);
        rd(12'h218, r); chk("R2 unmapped 218", r, 32'h0);
        rd(12'h000, r); chk("R2 unmapped 000", r, 32'h0);
        rd(12'h1FC, r); chk("R2 unmapped 1FC", r, 32'h0);
        wr(A_STAT, 32'hFFFF_FFFF); rd(A_STAT, r); chk("R10 clear idle", r, 32'h0);

        // Vector table: modes R3..R8
        foreach (VECS[k]) begin
            vec_t v;
            logic [31:0] exp_stat;
            v = VECS[k];
            wr(A_EN, 32'h0);
            wr(A_CFG0 + 12'(4 * (v.line / 8)), 32'(v.mode) << (4 * (v.line % 8)));
            eint_in = '0;
            eint_in[v.line] = v.v0;
            idle(4);
            wr(A_STAT, 32'hFFFF_FFFF);
            wr(A_EN, 32'h1 << v.line);
            eint_in[v.line] = v.v1;
            idle(6);
            exp_stat = 32'(v.exp) << v.line;
            rd(A_STAT, r); chk($sformatf("R3-mode vec %0d pending", k), r, exp_stat);
            chk($sformatf("R12 vec %0d irq", k), {31'b0, irq}, {31'b0, v.exp});
        end

        // R13 latency, line 3 rising
        wr(A_EN, 32'h0);
        wr(A_CFG0, 32'h0);
        eint_in = '0;
        idle(4);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_EN, 32'h8);
        bus_addr = A_STAT;
        @(negedge clk);
        eint_in[3] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R13 pending after 2 edges", bus_rdata, 32'h0);
        @(posedge clk); #1;
        chk("R13 pending after 3 edges", bus_rdata, 32'h8);
        chk("R13 irq after 3 edges", {31'b0, irq}, 32'h0);
        @(posedge clk); #1;
        chk("R13 irq after 4 edges", {31'b0, irq}, 32'h1);

        // R9 disabled line is not remembered
        wr(A_EN, 32'h0);
        eint_in = '0;
        idle(4);
        wr(A_STAT, 32'hFFFF_FFFF);
        eint_in[5] = 1'b1;
        idle(5);
        rd(A_STAT, r); chk("R9 disabled pending", r, 32'h0);
        wr(A_EN, 32'h20);
        idle(4);
        rd(A_STAT, r); chk("R9 no stale event", r, 32'h0);
        chk("R9 irq", {31'b0, irq}, 32'h0);

        // R6 / R11 high level reasserts through a clear
        wr(A_EN, 32'h0);
        wr(A_CFG0, 32'h0000_0200);
        eint_in = '0;
        idle(4);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_EN, 32'h4);
        eint_in[2] = 1'b1;
        idle(5);
        wr(A_STAT, 32'h4);
        rd(A_STAT, r); chk("R11 set wins over clear (R6 level held)", r, 32'h4);
        eint_in[2] = 1'b0;
        idle(5);
        wr(A_STAT, 32'h4);
        rd(A_STAT, r); chk("R6 cleared after level drops", r, 32'h0);
        idle(2);
        chk("R6 irq low", {31'b0, irq}, 32'h0);

        // R12 disable drops irq, R10 clear while disabled
        wr(A_EN, 32'h0);
        wr(12'h208, 32'h0);
        idle(4);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_EN, 32'h0010_0000);
        eint_in[20] = 1'b1;
        idle(5);
        chk("R12 irq pending", {31'b0, irq}, 32'h1);
        wr(A_EN, 32'h0);
        idle(1);
        chk("R12 irq drops on disable", {31'b0, irq}, 32'h0);
        rd(A_STAT, r); chk("R12 bit kept", r, 32'h0010_0000);
        wr(A_STAT, 32'h0);
        rd(A_STAT, r); chk("R10 zero write keeps", r, 32'h0010_0000);
        wr(A_STAT, 32'h0010_0000);
        rd(A_STAT, r); chk("R10 clear while disabled", r, 32'h0);
        wr(A_EN, 32'h0010_0000);
        idle(3);
        chk("R9 no later irq", {31'b0, irq}, 32'h0);

        // R10 partial clear of two pending lines
        wr(A_EN, 32'h0);
        wr(12'h20C, 32'h0);
        eint_in = '0;
        idle(4);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_EN, 32'h4000_0002);
        eint_in[1]  = 1'b1;
        eint_in[30] = 1'b1;
        idle(5);
        rd(A_STAT, r); chk("R10 both pending", r, 32'h4000_0002);
        wr(A_STAT, 32'h2);
        rd(A_STAT, r); chk("R10 partial clear", r, 32'h4000_0000);
        idle(2);
        chk("R12 irq remains", {31'b0, irq}, 32'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule